// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block takes every trap source of a small 32-bit in-order core: an external interrupt request, a hardware exception, an MMU fault, and hardware or software breaks. It decides which one is taken and computes, in one clock, every piece of architectural state the core must update on entry. That state is the new status word, the link value and which link register receives it, the exception status word, the faulting address, the saved branch target, and the next program counter. The next program counter is either a fixed offset from a vector base input or the pending branch target.

The core presents its current PC, status word, delay-slot and immediate-prefix flags, pending branch target and fault information on the inputs. One clock later the block drives registered result values, together with one-cycle write strobes that the core applies to its register file and special registers. An MMU fault that arrives while an earlier MMU fault is still being handled sets a sticky fatal flag and takes no trap. Only reset clears that flag.

Top module: `trap_entry_ctrl`

## Requirements
- R1: An interrupt is taken (irq_taken_o pulses) only if irq_req_i is high, status bit 0 (interrupt enable) is 1, status bit 2 (exception active) and bit 1 (break active) are 0, and in_dslot_i and imm_pfx_i are both 0.
- R2: On any taken trap, status_o equals status_i with bit 4 (user mode) copied to bit 5 and bit 6 (virtual mode) copied to bit 7, and bits 4 and 6 cleared. All other bits pass through unchanged unless another requirement changes them.
- R3: An interrupt additionally clears status bit 0, writes pc_i to link register 14 (lr14_we_o), and sets pc_o to vec_base_i + 0x10.
- R4: A hardware exception writes pc_i + 4 to link register 17, sets status bit 2, and sets pc_o to vec_base_i + 0x20.
- R5: For a hardware exception or an MMU fault, esr_o bit 12 equals in_dslot_i. When in_dslot_i is 1, btr_o receives branch_tgt_i with btr_we_o. For a hardware exception, every other esr_o bit is copied from esr_i.
- R6: An MMU fault writes a value to link register 17 and sets status bit 2 and pc_o = vec_base_i + 0x20. The value is pc_i minus 8 when in_dslot_i and imm_pfx_i are both 1, minus 4 when exactly one of them is 1, and unchanged when neither is.
- R7: An MMU fault gives esr_o bits [4:0] = 16 + 2*mmu_miss_i + fetch, and bit 10 = store. Here mmu_access_i encodes 0 load, 1 store, 2 fetch, 3 load. All other esr_o bits except bit 12 are 0. ear_o receives fault_addr_i.
- R8: A hardware break writes pc_i to link register 16, sets status bit 1, and sets pc_o to vec_base_i + 0x18. A software break sets status bit 1 and pc_o = branch_tgt_i, with no link write.
- R9: clr_flags_o pulses for every taken hardware exception or MMU fault and for no other trap.
- R10: An MMU fault that arrives while status bit 2 is set, and the last trap taken was an MMU fault, raises fatal_o and takes no trap. fatal_o then stays high until reset.
- R11: A hardware exception with exc_en_i low is ignored and produces no strobe.
- R12: When several sources are active, priority is MMU fault, hardware exception, hardware break, software break, interrupt.
- R13: After reset every strobe and fatal_o are 0. With no taken trap, every strobe is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vec_base_i | input | 32 | Vector base address |
| pc_i | input | 32 | Current program counter |
| branch_tgt_i | input | 32 | Pending branch target |
| status_i | input | 8 | Current status word |
| in_dslot_i | input | 1 | Current instruction sits in a branch delay slot |
| imm_pfx_i | input | 1 | Immediate prefix active (with in_dslot_i: the branch carried one) |
| esr_i | input | 32 | Current exception status word |
| exc_en_i | input | 1 | Hardware exceptions supported |
| irq_req_i | input | 1 | External interrupt pending |
| hw_exc_i | input | 1 | Hardware exception request |
| mmu_fault_i | input | 1 | MMU fault request |
| mmu_miss_i | input | 1 | Fault is a miss (1) or protection fault (0) |
| mmu_access_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| fault_addr_i | input | 32 | Faulting address |
| hw_brk_i | input | 1 | Hardware break request |
| sw_brk_i | input | 1 | Software break request |
| status_o | output | 8 | New status word |
| status_we_o | output | 1 | Status write strobe |
| pc_o | output | 32 | Next program counter |
| pc_we_o | output | 1 | PC write strobe |
| link_o | output | 32 | Link value |
| lr14_we_o | output | 1 | Write link value to register 14 |
| lr16_we_o | output | 1 | Write link value to register 16 |
| lr17_we_o | output | 1 | Write link value to register 17 |
| esr_o | output | 32 | New exception status word |
| esr_we_o | output | 1 | Exception status write strobe |
| ear_o | output | 32 | Exception address |
| ear_we_o | output | 1 | Exception address write strobe |
| btr_o | output | 32 | Saved branch target |
| btr_we_o | output | 1 | Branch target write strobe |
| clr_flags_o | output | 1 | Clear delay-slot and immediate-prefix flags |
| irq_taken_o | output | 1 | Interrupt accepted |
| fatal_o | output | 1 | Sticky recursive-fault flag |

## Verification
The interrupt gate is swept over all 256 status words crossed with both delay-slot and prefix flags. This separates each blocking condition from the mode-bit shift. MMU faults are swept over the status words that have exception-active clear, crossed with miss/protection, all four access codes and all four flag combinations. Together these tell the four fault codes, the store bit and the three link offsets apart. Hardware exceptions are swept with exc_en_i on and off, and breaks are swept over all status words. All 32 combinations of simultaneous sources check the priority. A deliberate second MMU fault checks the sticky fatal flag, and a later reset checks that it clears.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    TK_NONE, TK_IRQ, TK_HWEXC, TK_MMU, TK_HWBRK, TK_SWBRK, TK_FATAL
  } trap_kind_e;

  // status word bit positions; saved copy sits one above each live mode bit
  localparam int ST_IE  = 0;
  localparam int ST_BIP = 1;
  localparam int ST_EIP = 2;
  localparam int ST_UM  = 4;
  localparam int ST_VM  = 6;
  localparam int N_MODE = 2;

  localparam int ESR_ST_BIT = 10;
  localparam int ESR_DS_BIT = 12;
  localparam int ESR_MMU_BASE = 16;

  localparam logic [31:0] OFF_IRQ = 32'h10;
  localparam logic [31:0] OFF_BRK = 32'h18;
  localparam logic [31:0] OFF_EXC = 32'h20;

  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic       irq_req_i,
  input  logic       ie_i,
  input  logic       eip_i,
  input  logic       bip_i,
  input  logic       dslot_i,
  input  logic       imm_i,
  input  logic       hw_exc_i,
  input  logic       exc_en_i,
  input  logic       mmu_fault_i,
  input  logic       mmu_active_i,
  input  logic       hw_brk_i,
  input  logic       sw_brk_i,
  output trap_kind_e kind_o
);
  logic irq_ok;
  assign irq_ok = irq_req_i & ie_i & ~eip_i & ~bip_i & ~dslot_i & ~imm_i;

  always_comb begin
    if (mmu_fault_i)               kind_o = (mmu_active_i && eip_i) ? TK_FATAL : TK_MMU;
    else if (hw_exc_i && exc_en_i) kind_o = TK_HWEXC;
    else if (hw_brk_i)             kind_o = TK_HWBRK;
    else if (sw_brk_i)             kind_o = TK_SWBRK;
    else if (irq_ok)               kind_o = TK_IRQ;
    else                           kind_o = TK_NONE;
  end
endmodule

// File: rtl/trap_status_calc.sv
module trap_status_calc
  import trap_pkg::*;
#(
  parameter int ST_W = 8
) (
  input  trap_kind_e        kind_i,
  input  logic [ST_W-1:0]   status_i,
  output logic [ST_W-1:0]   status_o
);
  localparam int MODE_POS [N_MODE] = '{ST_UM, ST_VM};

  always_comb begin
    status_o = status_i;
    for (int k = 0; k < N_MODE; k++) begin
      status_o[MODE_POS[k]+1] = status_i[MODE_POS[k]];
      status_o[MODE_POS[k]]   = 1'b0;
    end
    unique case (kind_i)
      TK_IRQ:            status_o[ST_IE]  = 1'b0;
      TK_HWEXC, TK_MMU:  status_o[ST_EIP] = 1'b1;
      TK_HWBRK, TK_SWBRK: status_o[ST_BIP] = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_target_calc.sv
module trap_target_calc
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  trap_kind_e      kind_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] vec_base_i,
  input  logic [XLEN-1:0] branch_tgt_i,
  input  logic            dslot_i,
  input  logic            imm_i,
  output logic [XLEN-1:0] link_o,
  output logic [XLEN-1:0] pc_o,
  output logic            we14_o,
  output logic            we16_o,
  output logic            we17_o
);
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  // refetch the prefix and/or branch that the faulting slot depends on
  logic [XLEN-1:0] back;
  always_comb begin
    back = '0;
    if (dslot_i) back = imm_i ? (WORD << 1) : WORD;
    else if (imm_i) back = WORD;
  end

  always_comb begin
    link_o = pc_i;
    pc_o   = pc_i;
    we14_o = 1'b0;
    we16_o = 1'b0;
    we17_o = 1'b0;
    unique case (kind_i)
      TK_IRQ: begin
        we14_o = 1'b1;
        pc_o   = vec_base_i + XLEN'(OFF_IRQ);
      end
      TK_HWEXC: begin
        link_o = pc_i + WORD;
        we17_o = 1'b1;
        pc_o   = vec_base_i + XLEN'(OFF_EXC);
      end
      TK_MMU: begin
        link_o = pc_i - back;
        we17_o = 1'b1;
        pc_o   = vec_base_i + XLEN'(OFF_EXC);
      end
      TK_HWBRK: begin
        we16_o = 1'b1;
        pc_o   = vec_base_i + XLEN'(OFF_BRK);
      end
      TK_SWBRK: pc_o = branch_tgt_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_fault_code.sv
module trap_fault_code
  import trap_pkg::*;
#(
  parameter int ESR_W = 32
) (
  input  trap_kind_e       kind_i,
  input  logic [ESR_W-1:0] esr_i,
  input  logic             dslot_i,
  input  logic             miss_i,
  input  logic [1:0]       access_i,
  output logic [ESR_W-1:0] esr_o,
  output logic             esr_we_o,
  output logic             ear_we_o,
  output logic             btr_we_o,
  output logic             clr_o
);
  logic is_fetch, is_store, exc_like;
  assign is_fetch = (access_i == ACC_FETCH);
  assign is_store = (access_i == ACC_STORE);
  assign exc_like = (kind_i == TK_HWEXC) || (kind_i == TK_MMU);

  always_comb begin
    esr_o = esr_i;
    if (kind_i == TK_MMU) begin
      esr_o = ESR_W'(ESR_MMU_BASE);
      esr_o[1] = miss_i;
      esr_o[0] = is_fetch;
      esr_o[ESR_ST_BIT] = is_store;
    end
    esr_o[ESR_DS_BIT] = dslot_i;
  end

  assign esr_we_o = exc_like;
  assign ear_we_o = (kind_i == TK_MMU);
  assign btr_we_o = exc_like & dslot_i;
  assign clr_o    = exc_like;
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int ST_W  = 8,
  parameter int ESR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [XLEN-1:0]  vec_base_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  branch_tgt_i,
  input  logic [ST_W-1:0]  status_i,
  input  logic             in_dslot_i,
  input  logic             imm_pfx_i,
  input  logic [ESR_W-1:0] esr_i,
  input  logic             exc_en_i,
  input  logic             irq_req_i,
  input  logic             hw_exc_i,
  input  logic             mmu_fault_i,
  input  logic             mmu_miss_i,
  input  logic [1:0]       mmu_access_i,
  input  logic [XLEN-1:0]  fault_addr_i,
  input  logic             hw_brk_i,
  input  logic             sw_brk_i,
  output logic [ST_W-1:0]  status_o,
  output logic             status_we_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             pc_we_o,
  output logic [XLEN-1:0]  link_o,
  output logic             lr14_we_o,
  output logic             lr16_we_o,
  output logic             lr17_we_o,
  output logic [ESR_W-1:0] esr_o,
  output logic             esr_we_o,
  output logic [XLEN-1:0]  ear_o,
  output logic             ear_we_o,
  output logic [XLEN-1:0]  btr_o,
  output logic             btr_we_o,
  output logic             clr_flags_o,
  output logic             irq_taken_o,
  output logic             fatal_o
);
  trap_kind_e      kind;
  logic            mmu_active_q;
  logic [ST_W-1:0] st_n;
  logic [XLEN-1:0] link_n, pc_n;
  logic            we14_n, we16_n, we17_n;
  logic [ESR_W-1:0] esr_n;
  logic            esr_we_n, ear_we_n, btr_we_n, clr_n;
  logic            taken;

  trap_arbiter i_arb (
    .irq_req_i   (irq_req_i),
    .ie_i        (status_i[ST_IE]),
    .eip_i       (status_i[ST_EIP]),
    .bip_i       (status_i[ST_BIP]),
    .dslot_i     (in_dslot_i),
    .imm_i       (imm_pfx_i),
    .hw_exc_i    (hw_exc_i),
    .exc_en_i    (exc_en_i),
    .mmu_fault_i (mmu_fault_i),
    .mmu_active_i(mmu_active_q),
    .hw_brk_i    (hw_brk_i),
    .sw_brk_i    (sw_brk_i),
    .kind_o      (kind)
  );

  trap_status_calc #(.ST_W(ST_W)) i_st (
    .kind_i  (kind),
    .status_i(status_i),
    .status_o(st_n)
  );

  trap_target_calc #(.XLEN(XLEN)) i_tgt (
    .kind_i      (kind),
    .pc_i        (pc_i),
    .vec_base_i  (vec_base_i),
    .branch_tgt_i(branch_tgt_i),
    .dslot_i     (in_dslot_i),
    .imm_i       (imm_pfx_i),
    .link_o      (link_n),
    .pc_o        (pc_n),
    .we14_o      (we14_n),
    .we16_o      (we16_n),
    .we17_o      (we17_n)
  );

  trap_fault_code #(.ESR_W(ESR_W)) i_fc (
    .kind_i  (kind),
    .esr_i   (esr_i),
    .dslot_i (in_dslot_i),
    .miss_i  (mmu_miss_i),
    .access_i(mmu_access_i),
    .esr_o   (esr_n),
    .esr_we_o(esr_we_n),
    .ear_we_o(ear_we_n),
    .btr_we_o(btr_we_n),
    .clr_o   (clr_n)
  );

  assign taken = (kind != TK_NONE) && (kind != TK_FATAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o     <= '0;
      status_we_o  <= 1'b0;
      pc_o         <= '0;
      pc_we_o      <= 1'b0;
      link_o       <= '0;
      lr14_we_o    <= 1'b0;
      lr16_we_o    <= 1'b0;
      lr17_we_o    <= 1'b0;
      esr_o        <= '0;
      esr_we_o     <= 1'b0;
      ear_o        <= '0;
      ear_we_o     <= 1'b0;
      btr_o        <= '0;
      btr_we_o     <= 1'b0;
      clr_flags_o  <= 1'b0;
      irq_taken_o  <= 1'b0;
      fatal_o      <= 1'b0;
      mmu_active_q <= 1'b0;
    end else begin
      status_we_o <= taken;
      pc_we_o     <= taken;
      lr14_we_o   <= we14_n;
      lr16_we_o   <= we16_n;
      lr17_we_o   <= we17_n;
      esr_we_o    <= esr_we_n;
      ear_we_o    <= ear_we_n;
      btr_we_o    <= btr_we_n;
      clr_flags_o <= clr_n;
      irq_taken_o <= (kind == TK_IRQ);
      if (kind == TK_FATAL) fatal_o <= 1'b1;
      if (taken) begin
        status_o     <= st_n;
        pc_o         <= pc_n;
        link_o       <= link_n;
        mmu_active_q <= (kind == TK_MMU);
      end
      if (esr_we_n) esr_o <= esr_n;
      if (ear_we_n) ear_o <= fault_addr_i;
      if (btr_we_n) btr_o <= branch_tgt_i;
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ST_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [ST_W-1:0] status_i,
  input logic            in_dslot_i,
  input logic            imm_pfx_i,
  input logic [ST_W-1:0] status_o,
  input logic            status_we_o,
  input logic            pc_we_o,
  input logic            lr14_we_o,
  input logic            lr16_we_o,
  input logic            lr17_we_o,
  input logic            clr_flags_o,
  input logic            irq_taken_o,
  input logic            fatal_o
);
  // R1
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_taken_o |-> ($past(status_i[ST_IE]) && !$past(status_i[ST_EIP]) &&
                     !$past(status_i[ST_BIP]) && !$past(in_dslot_i) && !$past(imm_pfx_i)));
  // R2
  mode_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_we_o |-> (!status_o[ST_UM] && !status_o[ST_VM]));
  // R3
  irq_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_taken_o |-> (lr14_we_o && pc_we_o && !status_o[ST_IE]));
  // R8
  one_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lr14_we_o, lr16_we_o, lr17_we_o}));
  // R9
  clr_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_flags_o |-> (lr17_we_o && status_o[ST_EIP]));
  // R10
  fatal_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN), .ST_W(ST_W)) i_trap_entry_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .status_i   (status_i),
  .in_dslot_i (in_dslot_i),
  .imm_pfx_i  (imm_pfx_i),
  .status_o   (status_o),
  .status_we_o(status_we_o),
  .pc_we_o    (pc_we_o),
  .lr14_we_o  (lr14_we_o),
  .lr16_we_o  (lr16_we_o),
  .lr17_we_o  (lr17_we_o),
  .clr_flags_o(clr_flags_o),
  .irq_taken_o(irq_taken_o),
  .fatal_o    (fatal_o)
);

// File: tb/test_trap_entry_ctrl.sv
`timescale 1ns/1ps
module test_trap_entry_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] vec_base_i = '0, pc_i = '0, branch_tgt_i = '0, esr_i = '0, fault_addr_i = '0;
  logic [7:0]  status_i = '0;
  logic        in_dslot_i = 0, imm_pfx_i = 0, exc_en_i = 0, irq_req_i = 0, hw_exc_i = 0;
  logic        mmu_fault_i = 0, mmu_miss_i = 0, hw_brk_i = 0, sw_brk_i = 0;
  logic [1:0]  mmu_access_i = '0;
  logic [7:0]  status_o;
  logic [31:0] pc_o, link_o, esr_o, ear_o, btr_o;
  logic status_we_o, pc_we_o, lr14_we_o, lr16_we_o, lr17_we_o, esr_we_o, ear_we_o, btr_we_o;
  logic clr_flags_o, irq_taken_o, fatal_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  bit b_fatal = 0, b_last_mmu = 0;

  always #10 clk_i = ~clk_i;

  trap_entry_ctrl i_trap_entry_ctrl (.*);

  task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tg, what, act, exp);
    end
  endtask

  function automatic logic [7:0] save_modes(input logic [7:0] s);
    logic [7:0] r;
    r = s & 8'h0F;
    r[5] = s[4];
    r[7] = s[6];
    return r;
  endfunction

  // strobe order: status,pc,lr14,lr16,lr17,esr,ear,btr,clr,irq,fatal
  task automatic step(input string tg);
    logic [10:0] es;
    logic [7:0]  est;
    logic [31:0] epc, elink, eesr;
    bit mmu_acc, fatal_now;
    string k;
    es = '0; est = '0; epc = '0; elink = '0; eesr = '0; k = "none"; fatal_now = 0;
    if (mmu_fault_i && b_last_mmu && status_i[2]) begin
      k = "fatal"; fatal_now = 1;
    end else if (mmu_fault_i) begin
      k = "mmu";
      elink = pc_i - ((in_dslot_i && imm_pfx_i) ? 32'd8 : (in_dslot_i || imm_pfx_i) ? 32'd4 : 32'd0);
      eesr = 32'd16 + (mmu_miss_i ? 32'd2 : 32'd0) + ((mmu_access_i == 2'd2) ? 32'd1 : 32'd0)
           + ((mmu_access_i == 2'd1) ? 32'h400 : 32'd0) + (in_dslot_i ? 32'h1000 : 32'd0);
      est = save_modes(status_i) | 8'h04;
      epc = vec_base_i + 32'h20;
      es = {1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,in_dslot_i,1'b1,1'b0,1'b0};
    end else if (hw_exc_i && exc_en_i) begin
      k = "hwexc";
      elink = pc_i + 32'd4;
      eesr = (esr_i & ~32'h1000) | (in_dslot_i ? 32'h1000 : 32'd0);
      est = save_modes(status_i) | 8'h04;
      epc = vec_base_i + 32'h20;
      es = {1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,in_dslot_i,1'b1,1'b0,1'b0};
    end else if (hw_brk_i) begin
      k = "hwbrk";
      elink = pc_i;
      est = save_modes(status_i) | 8'h02;
      epc = vec_base_i + 32'h18;
      es = 11'b11010000000;
    end else if (sw_brk_i) begin
      k = "swbrk";
      est = save_modes(status_i) | 8'h02;
      epc = branch_tgt_i;
      es = 11'b11000000000;
    end else if (irq_req_i && status_i[0] && !status_i[1] && !status_i[2] && !in_dslot_i && !imm_pfx_i) begin
      k = "irq";
      elink = pc_i;
      est = save_modes(status_i) & 8'hFE;
      epc = vec_base_i + 32'h10;
      es = 11'b11100000010;
    end
    if (fatal_now) b_fatal = 1;
    es[0] = b_fatal;
    if (k != "none" && k != "fatal") b_last_mmu = (k == "mmu");
    @(posedge clk_i); #1;
    chk(tg, {"strobes/", k}, 32'({status_we_o,pc_we_o,lr14_we_o,lr16_we_o,lr17_we_o,esr_we_o,
                                ear_we_o,btr_we_o,clr_flags_o,irq_taken_o,fatal_o}), 32'(es));
    if (es[10]) begin
      chk("R2", {"status/", k}, 32'(status_o), 32'(est));
      chk(tg, {"pc/", k}, pc_o, epc);
    end
    if (es[8] || es[7] || es[6]) chk(tg, {"link/", k}, link_o, elink);
    if (es[5]) chk((k == "mmu") ? "R7" : "R5", "esr", esr_o, eesr);
    if (es[4]) chk("R7", "ear", ear_o, fault_addr_i);
    if (es[3]) chk("R5", "btr", btr_o, branch_tgt_i);
  endtask

  task automatic clear_src();
    irq_req_i = 0; hw_exc_i = 0; mmu_fault_i = 0; hw_brk_i = 0; sw_brk_i = 0;
    in_dslot_i = 0; imm_pfx_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0; clear_src();
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1;
    b_fatal = 0; b_last_mmu = 0;
    @(posedge clk_i); #1;
    chk("R13", "reset strobes", 32'({status_we_o,pc_we_o,lr14_we_o,lr16_we_o,lr17_we_o,esr_we_o,
                                    ear_we_o,btr_we_o,clr_flags_o,irq_taken_o,fatal_o}), 32'd0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    exc_en_i = 1;
    // R1 R2 R3: interrupt gate over all status words and flags
    for (int s = 0; s < 256; s++)
      for (int f = 0; f < 4; f++) begin
        clear_src();
        irq_req_i = 1; status_i = 8'(s); in_dslot_i = f[0]; imm_pfx_i = f[1];
        pc_i = 32'h0010_0000 + 32'(s * 16 + f * 4);
        vec_base_i = s[0] ? 32'hFFFF_FF00 : 32'h0000_4000;
        step("R1");
      end
    clear_src(); irq_req_i = 0; step("R13");
    // R6 R7 R5: MMU faults, exception-active clear
    for (int s = 0; s < 256; s++) begin
      if (s[2]) continue;
      for (int v = 0; v < 32; v++) begin
        clear_src();
        mmu_fault_i = 1; status_i = 8'(s);
        mmu_miss_i = v[0]; mmu_access_i = 2'(v >> 1); in_dslot_i = v[3]; imm_pfx_i = v[4];
        pc_i = 32'h2000_0000 + 32'(s * 256 + v * 8);
        fault_addr_i = ~pc_i; branch_tgt_i = pc_i ^ 32'h00F0_0F00;
        vec_base_i = 32'h0000_8000 + 32'(s << 8);
        step("R6");
      end
    end
    // R4 R5 R11: hardware exceptions with support on and off
    for (int s = 0; s < 256; s++)
      for (int v = 0; v < 8; v++) begin
        clear_src();
        hw_exc_i = 1; exc_en_i = v[0]; in_dslot_i = v[1]; imm_pfx_i = v[2];
        status_i = 8'(s); esr_i = v[2] ? 32'hFFFF_F0F0 : 32'h0000_1005;
        pc_i = 32'h3000_0000 + 32'(s * 64 + v * 4); branch_tgt_i = ~pc_i;
        vec_base_i = 32'h0000_C000;
        step(v[0] ? "R4" : "R11");
      end
    exc_en_i = 1;
    // R8: breaks
    for (int s = 0; s < 256; s++)
      for (int b = 0; b < 2; b++) begin
        clear_src();
        hw_brk_i = b[0]; sw_brk_i = !b[0]; status_i = 8'(s);
        pc_i = 32'h4000_0000 + 32'(s * 8); branch_tgt_i = 32'h5000_0000 + 32'(s * 4);
        vec_base_i = 32'h0001_0000;
        step("R8");
      end
    // R12 R9: every combination of simultaneous sources
    for (int c = 0; c < 32; c++) begin
      clear_src();
      status_i = 8'h51;
      {mmu_fault_i, hw_exc_i, hw_brk_i, sw_brk_i, irq_req_i} = 5'(c);
      pc_i = 32'h6000_0000 + 32'(c * 4); branch_tgt_i = 32'h7000_0000; fault_addr_i = 32'hDEAD_0000;
      vec_base_i = 32'h0002_0000; esr_i = 32'h0000_00AA;
      step("R12");
    end
    // R11: unsupported exception lets the interrupt through
    clear_src(); exc_en_i = 0; hw_exc_i = 1; irq_req_i = 1; status_i = 8'h01; step("R11");
    exc_en_i = 1;
    // R10: recursive MMU fault
    clear_src(); status_i = 8'h00; mmu_fault_i = 1; step("R7");
    clear_src(); status_i = 8'h04; mmu_fault_i = 1; step("R10");
    clear_src(); status_i = 8'h01; irq_req_i = 1; step("R10");
    clear_src(); step("R10");
    do_reset();
    chk("R10", "fatal after reset", 32'(fatal_o), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule